// File: doc/BRIEF.md
# Polled Parallel-Port Handshake Target

This block is the board-side end of a shared 8-bit parallel port with several drop points. A host selects one board at a time on a small select bus. Each board compares that bus with its own fixed address. Bytes cross the port in either direction through a request/acknowledge pair.

For an outgoing byte, local logic hands the byte over through a valid/ready pair. The block holds the byte in a latch and raises a request. The port sees that request only while the host has this board selected, so a waiting board stays hidden until the host polls it. When the host acknowledges, the block withdraws its request. It then enables its bus driver for as long as the acknowledge is held. When the host releases the acknowledge, the block disables the driver and returns to idle.

For an incoming byte, a host request on the selected board makes the block capture the bus. It reports the byte with a one-cycle strobe and answers with an acknowledge. The acknowledge stays up until the host drops its request. All host-driven lines pass through synchronizers before the controller uses them. The tri-state driver is modelled as an output enable.

Top module: `parport_target`

## Requirements
- R1: While the synchronous active-high reset is held, and on the first cycle after it is released, boardReq, boardAck, portDataOe and rxValid are 0 and txReady is 1.
- R2: txReady is 1 only while the block is idle and no selected host request is pending. A byte is taken on the rising edge where txValid and txReady are both 1. After that edge txReady stays 0 until the cycle ends.
- R3: While a board-to-host byte is pending, boardReq is 1 only while the synchronized select equals BOARD_ADDR. Deselecting the board drops boardReq but keeps the byte pending.
- R4: The select, hostReq and hostAck inputs each pass through a two-stage synchronizer. A change driven between edges becomes visible at the outputs on the second following rising edge.
- R5: Once the synchronized hostAck is seen high while the board is selected and a request is pending, boardReq falls and portDataOe rises on the next edge. portDataOut then carries the accepted byte.
- R6: portDataOe stays 1 with portDataOut unchanged while hostAck is held. When the synchronized hostAck falls, portDataOe falls. One edge later the block is idle again and txReady returns to 1.
- R7: Deselecting the board during the drive phase drops portDataOe. Selecting it again while hostAck is still held restores portDataOe with the same byte.
- R8: A synchronized hostReq with the board selected, seen in idle, captures portDataIn into rxData. rxValid is 1 for exactly one cycle and boardAck rises on the same edge.
- R9: boardAck stays 1 while hostReq is held. It falls on the edge after the synchronized hostReq is seen low, and each host-to-board transfer yields exactly one rxValid pulse.
- R10: A hostReq raised while the select does not equal BOARD_ADDR is ignored. boardAck and rxValid stay 0 and txReady stays 1.
- R11: When a selected host request and txValid are both present in idle, the host request wins. txReady is 0 and the block enters the acknowledge phase.
- R12: Reset applied in the middle of a cycle abandons it. boardReq, boardAck and portDataOe fall and txReady returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| boardSel | input | ADDR_W | Host select lines (asynchronous) |
| hostReq | input | 1 | Host request for a host-to-board byte (asynchronous) |
| hostAck | input | 1 | Host acknowledge of a board-to-host request (asynchronous) |
| portDataIn | input | DATA_W | Data bus as seen by the board |
| portDataOut | output | DATA_W | Byte the board drives when enabled |
| portDataOe | output | 1 | Data bus driver enable |
| boardReq | output | 1 | Board request, gated by select match |
| boardAck | output | 1 | Board acknowledge of a host write, gated by select match |
| txValid | input | 1 | Local byte offered for sending |
| txData | input | DATA_W | Local byte to send |
| txReady | output | 1 | Block can accept a local byte |
| rxValid | output | 1 | One-cycle strobe for a received byte |
| rxData | output | DATA_W | Last received byte |

## Verification
The bench builds the block with BOARD_ADDR set to 6 and keeps the 3-bit select, the 8-bit bus and two synchronizer stages. Driving select code 2 as a foreign board lets it hide and reveal the pending request, cut the driver mid-transfer and show that foreign host writes are ignored. With the stage count fixed at two, the bench can check the exact edge on which each synchronized host line takes effect.

// File: rtl/parport_pkg.sv
package parport_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TX_REQ,
    ST_TX_DRIVE,
    ST_RX_ACK
  } portState_e;

  typedef struct packed {
    logic loadTx;
    logic captureRx;
  } dpCtrl_t;

endpackage

// File: rtl/parport_sync.sv
module parport_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/parport_ctrl.sv
module parport_ctrl
  import parport_pkg::*;
#(
  parameter int                ADDR_W     = 3,
  parameter logic [ADDR_W-1:0] BOARD_ADDR = 3'd5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] selSync,
  input  logic              hostReqSync,
  input  logic              hostAckSync,
  input  logic              txValid,
  output logic              txReady,
  output logic              boardReq,
  output logic              boardAck,
  output logic              dataOe,
  output dpCtrl_t           dpCtrl
);

  portState_e state, stateNext;
  logic addrHit;
  logic rxStart;

  assign addrHit = (selSync == BOARD_ADDR);
  assign rxStart = hostReqSync && addrHit;

  always_comb begin
    stateNext        = state;
    dpCtrl.loadTx    = 1'b0;
    dpCtrl.captureRx = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (rxStart) begin
          dpCtrl.captureRx = 1'b1;
          stateNext        = ST_RX_ACK;
        end else if (txValid) begin
          dpCtrl.loadTx = 1'b1;
          stateNext     = ST_TX_REQ;
        end
      end
      ST_TX_REQ:   if (hostAckSync && addrHit) stateNext = ST_TX_DRIVE;
      ST_TX_DRIVE: if (!hostAckSync) stateNext = ST_IDLE;
      ST_RX_ACK:   if (!hostReqSync) stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign txReady  = (state == ST_IDLE) && !rxStart;
  assign boardReq = (state == ST_TX_REQ) && addrHit;
  assign dataOe   = (state == ST_TX_DRIVE) && hostAckSync && addrHit;
  assign boardAck = (state == ST_RX_ACK) && addrHit;

endmodule

// File: rtl/parport_dp.sv
module parport_dp
  import parport_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtrl_t           dpCtrl,
  input  logic [DATA_W-1:0] txData,
  input  logic [DATA_W-1:0] portDataIn,
  output logic [DATA_W-1:0] portDataOut,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid
);

  logic [DATA_W-1:0] txLatch;
  logic [DATA_W-1:0] rxLatch;
  logic              rxStrobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      txLatch  <= '0;
      rxLatch  <= '0;
      rxStrobe <= 1'b0;
    end else begin
      if (dpCtrl.loadTx)    txLatch <= txData;
      if (dpCtrl.captureRx) rxLatch <= portDataIn;
      rxStrobe <= dpCtrl.captureRx;
    end
  end

  assign portDataOut = txLatch;
  assign rxData      = rxLatch;
  assign rxValid     = rxStrobe;

endmodule

// File: rtl/parport_target.sv
module parport_target
  import parport_pkg::*;
#(
  parameter int                ADDR_W      = 3,
  parameter int                DATA_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] BOARD_ADDR  = 3'd5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] boardSel,
  input  logic              hostReq,
  input  logic              hostAck,
  input  logic [DATA_W-1:0] portDataIn,
  output logic [DATA_W-1:0] portDataOut,
  output logic              portDataOe,
  output logic              boardReq,
  output logic              boardAck,
  input  logic              txValid,
  input  logic [DATA_W-1:0] txData,
  output logic              txReady,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData
);

  localparam int SYNC_W = ADDR_W + 2;

  logic [SYNC_W-1:0] hostLinesSync;
  logic [ADDR_W-1:0] selSync;
  logic              hostReqSync;
  logic              hostAckSync;
  dpCtrl_t           dpCtrl;

  parport_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst     (rst),
    .asyncIn ({boardSel, hostReq, hostAck}),
    .syncOut (hostLinesSync)
  );

  assign {selSync, hostReqSync, hostAckSync} = hostLinesSync;

  parport_ctrl #(.ADDR_W(ADDR_W), .BOARD_ADDR(BOARD_ADDR)) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .selSync     (selSync),
    .hostReqSync (hostReqSync),
    .hostAckSync (hostAckSync),
    .txValid     (txValid),
    .txReady     (txReady),
    .boardReq    (boardReq),
    .boardAck    (boardAck),
    .dataOe      (portDataOe),
    .dpCtrl      (dpCtrl)
  );

  parport_dp #(.DATA_W(DATA_W)) dp_i (
    .clk         (clk),
    .rst         (rst),
    .dpCtrl      (dpCtrl),
    .txData      (txData),
    .portDataIn  (portDataIn),
    .portDataOut (portDataOut),
    .rxData      (rxData),
    .rxValid     (rxValid)
  );

endmodule

// File: rtl/parport_target_chk.sv
module parport_target_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              boardReq,
  input logic              boardAck,
  input logic              portDataOe,
  input logic [DATA_W-1:0] portDataOut,
  input logic              txReady,
  input logic              rxValid
);

  // R2: an idle, ready block shows no handshake activity on the port
  a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (rst)
    txReady |-> (!boardReq && !boardAck && !portDataOe));

  // R5: request and driver enable never overlap
  a_r5_req_oe_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(boardReq && portDataOe));

  // R6: the driven byte holds while the driver stays enabled
  a_r6_data_held: assert property (@(posedge clk) disable iff (rst)
    portDataOe |=> (!portDataOe || $stable(portDataOut)));

  // R8: acknowledge of a host write excludes outgoing activity
  a_r8_ack_excludes_tx: assert property (@(posedge clk) disable iff (rst)
    boardAck |-> (!boardReq && !portDataOe));

  // R9: a received byte is flagged for a single cycle
  a_r9_rx_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rxValid |=> !rxValid);

endmodule

bind parport_target parport_target_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .boardReq    (boardReq),
  .boardAck    (boardAck),
  .portDataOe  (portDataOe),
  .portDataOut (portDataOut),
  .txReady     (txReady),
  .rxValid     (rxValid)
);

// File: tb/parport_target_tb_top.sv
module parport_target_tb_top;

  localparam int          CLK_PERIOD = 10;
  localparam int          ADDR_W     = 3;
  localparam int          DATA_W     = 8;
  localparam logic [2:0]  MY_ADDR    = 3'd6;
  localparam logic [2:0]  OTHER_ADDR = 3'd2;
  localparam int          WATCHDOG   = 20000;

  logic              clk = 1'b0;
  logic              rst;
  logic [ADDR_W-1:0] boardSel;
  logic              hostReq;
  logic              hostAck;
  logic [DATA_W-1:0] portDataIn;
  logic [DATA_W-1:0] portDataOut;
  logic              portDataOe;
  logic              boardReq;
  logic              boardAck;
  logic              txValid;
  logic [DATA_W-1:0] txData;
  logic              txReady;
  logic              rxValid;
  logic [DATA_W-1:0] rxData;

  int checks = 0;
  int fails  = 0;
  int rxCount = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  parport_target #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(2), .BOARD_ADDR(MY_ADDR)
  ) dut_i (
    .clk(clk), .rst(rst), .boardSel(boardSel), .hostReq(hostReq),
    .hostAck(hostAck), .portDataIn(portDataIn), .portDataOut(portDataOut),
    .portDataOe(portDataOe), .boardReq(boardReq), .boardAck(boardAck),
    .txValid(txValid), .txData(txData), .txReady(txReady),
    .rxValid(rxValid), .rxData(rxData)
  );

  always @(negedge clk) if (!rst && rxValid) rxCount++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic testReset();
    rst = 1'b1; boardSel = '0; hostReq = 0; hostAck = 0;
    portDataIn = '0; txValid = 0; txData = '0;
    tick(3);
    chk("R1", "boardReq in reset", boardReq, 0);
    chk("R1", "txReady in reset", txReady, 1);
    rst = 1'b0;
    tick(1);
    chk("R1", "boardReq", boardReq, 0);
    chk("R1", "boardAck", boardAck, 0);
    chk("R1", "portDataOe", portDataOe, 0);
    chk("R1", "rxValid", rxValid, 0);
    chk("R1", "txReady", txReady, 1);
  endtask

  task automatic testTxHandshake();
    txValid = 1; txData = 8'hA5;
    tick(1);
    txValid = 0;
    chk("R2", "txReady after accept", txReady, 0);
    chk("R3", "boardReq hidden while unselected", boardReq, 0);
    boardSel = MY_ADDR;
    tick(1);
    chk("R4", "boardReq one edge after select", boardReq, 0);
    tick(1);
    chk("R4", "boardReq two edges after select", boardReq, 1);
    hostAck = 1;
    tick(2);
    chk("R5", "boardReq before FSM sees ack", boardReq, 1);
    tick(1);
    chk("R5", "boardReq dropped", boardReq, 0);
    chk("R5", "portDataOe raised", portDataOe, 1);
    chk("R5", "portDataOut", portDataOut, 8'hA5);
    tick(4);
    chk("R6", "portDataOe held", portDataOe, 1);
    chk("R6", "portDataOut held", portDataOut, 8'hA5);
    hostAck = 0;
    tick(2);
    chk("R6", "portDataOe dropped", portDataOe, 0);
    chk("R6", "txReady still low", txReady, 0);
    tick(1);
    chk("R6", "txReady back", txReady, 1);
    boardSel = OTHER_ADDR;
    tick(3);
  endtask

  task automatic testDeselectMidCycle();
    txValid = 1; txData = 8'h5C;
    tick(1);
    txValid = 0;
    boardSel = MY_ADDR;
    tick(2);
    chk("R3", "boardReq when selected", boardReq, 1);
    boardSel = OTHER_ADDR;
    tick(2);
    chk("R3", "boardReq after deselect", boardReq, 0);
    chk("R3", "byte still pending", txReady, 0);
    boardSel = MY_ADDR; hostAck = 1;
    tick(3);
    chk("R7", "portDataOe selected", portDataOe, 1);
    boardSel = OTHER_ADDR;
    tick(2);
    chk("R7", "portDataOe cut by deselect", portDataOe, 0);
    boardSel = MY_ADDR;
    tick(2);
    chk("R7", "portDataOe restored", portDataOe, 1);
    chk("R7", "portDataOut restored", portDataOut, 8'h5C);
    hostAck = 0;
    tick(3);
    chk("R6", "idle after ack release", txReady, 1);
    boardSel = OTHER_ADDR;
    tick(3);
  endtask

  task automatic testRx();
    int startCount;
    startCount = rxCount;
    boardSel = MY_ADDR; portDataIn = 8'h3C; hostReq = 1;
    tick(2);
    chk("R8", "no ack before sync", boardAck, 0);
    tick(1);
    chk("R8", "rxValid pulse", rxValid, 1);
    chk("R8", "rxData", rxData, 8'h3C);
    chk("R8", "boardAck raised", boardAck, 1);
    portDataIn = 8'hFF;
    tick(1);
    chk("R8", "rxValid single cycle", rxValid, 0);
    tick(3);
    chk("R9", "boardAck held", boardAck, 1);
    hostReq = 0;
    tick(2);
    chk("R9", "boardAck before FSM sees drop", boardAck, 1);
    tick(1);
    chk("R9", "boardAck released", boardAck, 0);
    chk("R9", "one pulse per transfer", rxCount - startCount, 1);
    chk("R9", "rxData kept", rxData, 8'h3C);
    boardSel = OTHER_ADDR;
    tick(3);
  endtask

  task automatic testRxIgnored();
    int startCount;
    startCount = rxCount;
    boardSel = OTHER_ADDR; portDataIn = 8'h77; hostReq = 1;
    tick(6);
    chk("R10", "boardAck", boardAck, 0);
    chk("R10", "txReady", txReady, 1);
    chk("R10", "rxValid count", rxCount - startCount, 0);
    chk("R10", "rxData unchanged", rxData, 8'h3C);
    hostReq = 0;
    tick(3);
  endtask

  task automatic testPriority();
    boardSel = MY_ADDR; portDataIn = 8'h81; hostReq = 1;
    tick(2);
    txValid = 1; txData = 8'h42;
    #1;
    chk("R11", "txReady blocked", txReady, 0);
    tick(1);
    txValid = 0;
    chk("R11", "boardAck wins", boardAck, 1);
    chk("R11", "boardReq absent", boardReq, 0);
    chk("R11", "rxData", rxData, 8'h81);
    hostReq = 0;
    tick(3);
    chk("R11", "txReady after rx", txReady, 1);
    boardSel = OTHER_ADDR;
    tick(3);
  endtask

  task automatic testMidReset();
    boardSel = MY_ADDR;
    txValid = 1; txData = 8'h99;
    tick(1);
    txValid = 0;
    tick(2);
    chk("R12", "boardReq before reset", boardReq, 1);
    rst = 1;
    tick(1);
    chk("R12", "boardReq in reset", boardReq, 0);
    chk("R12", "portDataOe in reset", portDataOe, 0);
    chk("R12", "txReady in reset", txReady, 1);
    rst = 0;
    tick(3);
    chk("R12", "boardReq after reset", boardReq, 0);
    chk("R12", "boardAck after reset", boardAck, 0);
    chk("R12", "txReady after reset", txReady, 1);
  endtask

  initial begin
    testReset();
    testTxHandshake();
    testDeselectMidCycle();
    testRx();
    testRxIgnored();
    testPriority();
    testMidReset();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule